// File: doc/BRIEF.md
# Programmable Line Sync Generator

This block derives horizontal timing for a video output port. A free-running counter advances once per pixel clock and wraps after a programmable number of pixels. Two compare values on that counter bound a horizontal control window, driven out as a single level. An incoming vertical sync pulse is retimed by a programmable delay, counted in units of eight pixel clocks. The width of the pulse is kept.

Configuration uses a small register port with 8-bit subaddresses and 16-bit data. Writes are sampled on a clock edge. Read data is a combinational decode of the current subaddress. A line-length change waits for the end of the running line, so a line is never cut short or left running past its new end. The counter value, the window level and the delayed vertical sync all leave the block as plain outputs.

Top module: `lsg_line_sync`

## Requirements
- R1: The sync counter steps by one on each clock from 0 up to the active line-length value L inclusive, then returns to 0, giving a line period of L+1 clocks.
- R2: Line length is held in bits 10:0 of subaddress 0x21 and resets to 1295. Bits 15:11 of that word, and of the window registers, are dropped on write and read back as zero.
- R3: A new line length takes effect at the next counter wrap. The line in progress still ends at the old value.
- R4: Window start sits at subaddress 0x26 (bits 10:0, reset 50) and window stop at 0x27 (bits 10:0, reset 800). When start ≤ stop, the window output is high exactly while start ≤ counter < stop.
- R5: When start > stop, the window output is high while counter ≥ start or counter < stop, so it wraps through the line end. When start equals stop it is never high.
- R6: The delay code D sits at subaddress 0x30, bits 7:0, and resets to 0. The delayed sync output rises on the 8·D-th clock edge after the first edge that samples the input high. For D = 0 that is the same edge.
- R7: The falling edge is delayed by the same 8·D edges, so the output pulse is as wide as the input pulse. This holds even when the pulse is shorter than the delay.
- R8: Subaddresses other than 0x21, 0x26, 0x27 and 0x30 read as zero. Writes to them change no register.
- R9: A synchronous active-low reset restores every register to its reset value, clears the counter to 0 and drives the delayed sync low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr | input | 1 | Write strobe, sampled on the clock edge |
| cfg_addr | input | 8 | Register subaddress |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data for cfg_addr (combinational) |
| vs_in | input | 1 | Vertical sync input |
| sync_cnt | output | 11 | Current sync counter value |
| hc_out | output | 1 | Horizontal control window |
| vs_out | output | 1 | Delayed vertical sync |

## Verification
A stale or wrong active line length shows on the counter output within one line: either the wrap point or the period of the following line moves. A fault in the window compare shows on hc_out within a single line for the affected start and stop pair, so each table vector walks one full line cycle by cycle. A lost or mistimed load in either edge down-counter shifts the rising or falling edge of vs_out by a whole number of clocks. That shift is seen on the first pulse after the fault, by measuring both edge positions and the output pulse width.

// File: rtl/lsg_pkg.sv
// Shared constants for the line sync generator: register subaddresses,
// field widths and reset values. Assumes an 8-bit subaddress space.
package lsg_pkg;
    localparam int CNT_W      = 11;
    localparam int DLY_W      = 8;
    localparam int STEP_SHIFT = 3;
    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 8;

    localparam logic [7:0] SUB_LINE_LEN = 8'h21;
    localparam logic [7:0] SUB_HC_ON    = 8'h26;
    localparam logic [7:0] SUB_HC_OFF   = 8'h27;
    localparam logic [7:0] SUB_VS_DLY   = 8'h30;

    localparam int RST_LINE_LEN = 1295;
    localparam int RST_HC_ON    = 50;
    localparam int RST_HC_OFF   = 800;
    localparam int RST_VS_DLY   = 0;
endpackage

// File: rtl/lsg_regs.sv
// Configuration register file. Four fields are written on the clock edge
// and read back through a combinational decode. Assumes DATA_W >= CNT_W
// and DATA_W >= DLY_W. Unknown subaddresses read zero and ignore writes.
module lsg_regs
    import lsg_pkg::*;
#(
    parameter int CNT_W  = lsg_pkg::CNT_W,
    parameter int DLY_W  = lsg_pkg::DLY_W,
    parameter int DATA_W = lsg_pkg::DATA_W,
    parameter int ADDR_W = lsg_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  line_len,
    output logic [CNT_W-1:0]  hc_on,
    output logic [CNT_W-1:0]  hc_off,
    output logic [DLY_W-1:0]  vs_dly
);
    localparam logic [ADDR_W-1:0] A_LEN = ADDR_W'(SUB_LINE_LEN);
    localparam logic [ADDR_W-1:0] A_ON  = ADDR_W'(SUB_HC_ON);
    localparam logic [ADDR_W-1:0] A_OFF = ADDR_W'(SUB_HC_OFF);
    localparam logic [ADDR_W-1:0] A_DLY = ADDR_W'(SUB_VS_DLY);

    logic unused_wbits;
    assign unused_wbits = &{1'b0, wdata[DATA_W-1:CNT_W]};

    // Register update: reset defaults, or capture the addressed field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_len <= CNT_W'(RST_LINE_LEN);
            hc_on    <= CNT_W'(RST_HC_ON);
            hc_off   <= CNT_W'(RST_HC_OFF);
            vs_dly   <= DLY_W'(RST_VS_DLY);
        end else if (wr) begin
            case (addr)
                A_LEN:   line_len <= wdata[CNT_W-1:0];
                A_ON:    hc_on    <= wdata[CNT_W-1:0];
                A_OFF:   hc_off   <= wdata[CNT_W-1:0];
                A_DLY:   vs_dly   <= wdata[DLY_W-1:0];
                default: ;
            endcase
        end
    end

    // Read decode: zero-extended field, zero for unknown subaddresses.
    always_comb begin
        rdata = '0;
        case (addr)
            A_LEN:   rdata[CNT_W-1:0] = line_len;
            A_ON:    rdata[CNT_W-1:0] = hc_on;
            A_OFF:   rdata[CNT_W-1:0] = hc_off;
            A_DLY:   rdata[DLY_W-1:0] = vs_dly;
            default: ;
        endcase
    end

    assert_len_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_LEN) |=> line_len == $past(wdata[CNT_W-1:0]));

    assert_unknown_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr != A_LEN && addr != A_ON && addr != A_OFF && addr != A_DLY)
        |=> ($stable(line_len) && $stable(hc_on) && $stable(hc_off) && $stable(vs_dly)));
endmodule

// File: rtl/lsg_counter.sv
// Free-running sync counter and horizontal window compare. The counter
// runs 0..active_len and wraps; the programmed length is adopted only at
// a wrap. The window is a half-open start/stop compare that may wrap.
module lsg_counter #(
    parameter int CNT_W   = lsg_pkg::CNT_W,
    parameter int LEN_RST = lsg_pkg::RST_LINE_LEN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] len_cfg,
    input  logic [CNT_W-1:0] hc_on,
    input  logic [CNT_W-1:0] hc_off,
    output logic [CNT_W-1:0] cnt,
    output logic             hc
);
    logic [CNT_W-1:0] active_len;
    logic             at_end;

    assign at_end = (cnt == active_len);

    // Counter step and line-length hand-over at the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            active_len <= CNT_W'(LEN_RST);
        end else if (at_end) begin
            cnt        <= '0;
            active_len <= len_cfg;
        end else begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    // Window level: plain range, or wrapped range when start exceeds stop.
    always_comb begin
        if (hc_on <= hc_off) hc = (cnt >= hc_on) && (cnt < hc_off);
        else                 hc = (cnt >= hc_on) || (cnt < hc_off);
    end

    assert_cnt_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= active_len);

    assert_wrap_to_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        at_end |=> cnt == '0);

    assert_step_by_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !at_end |=> cnt == $past(cnt) + CNT_W'(1));

    assert_len_held_midline_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !at_end |=> $stable(active_len));
endmodule

// File: rtl/lsg_edge_delay.sv
// One edge channel of the sync delay: a down-counter loaded on a trigger.
// fire pulses for one cycle when the count expires, or at once when the
// load value is zero. Assumes triggers arrive no faster than the delay.
module lsg_edge_delay #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         trig,
    input  logic [W-1:0] load_val,
    output logic         fire
);
    logic [W-1:0] remain;

    // Down-counter: load on trigger, otherwise count toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              remain <= '0;
        else if (trig)           remain <= load_val;
        else if (remain != '0)   remain <= remain - W'(1);
    end

    // Expiry: immediate for a zero load, else on the last count.
    assign fire = trig ? (load_val == '0) : (remain == W'(1));

    assert_count_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && remain != '0) |=> remain == $past(remain) - W'(1));
endmodule

// File: rtl/lsg_vsdelay.sv
// Vertical sync delay. Detects both edges of vs_in and sends each through
// its own down-counter channel loaded with D*2^STEP_SHIFT, so the output
// pulse keeps the input width. Assumes like edges are spaced beyond the delay.
module lsg_vsdelay #(
    parameter int DLY_W      = lsg_pkg::DLY_W,
    parameter int STEP_SHIFT = lsg_pkg::STEP_SHIFT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vs_in,
    input  logic [DLY_W-1:0] vs_dly,
    output logic             vs_out
);
    localparam int LW = DLY_W + STEP_SHIFT;

    logic          vs_prev;
    logic [1:0]    trig;
    logic [1:0]    fire;
    logic [LW-1:0] load_val;

    assign load_val = {vs_dly, {STEP_SHIFT{1'b0}}};
    assign trig     = {~vs_in & vs_prev, vs_in & ~vs_prev};

    // Input history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) vs_prev <= 1'b0;
        else        vs_prev <= vs_in;
    end

    // Channel 0 delays the rising edge, channel 1 the falling edge.
    for (genvar g = 0; g < 2; g++) begin : g_edge
        lsg_edge_delay #(.W(LW)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .trig     (trig[g]),
            .load_val (load_val),
            .fire     (fire[g])
        );
    end

    // Output level: set by the rise channel, cleared by the fall channel.
    always_ff @(posedge clk) begin
        if (!rst_n)       vs_out <= 1'b0;
        else if (fire[1]) vs_out <= 1'b0;
        else if (fire[0]) vs_out <= 1'b1;
    end

    assert_rise_sets_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire[0] && !fire[1]) |=> vs_out);

    assert_fall_clears_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fire[1] |=> !vs_out);

    assert_idle_holds_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fire == 2'b00) |=> $stable(vs_out));
endmodule

// File: rtl/lsg_line_sync.sv
// Top of the line sync generator: register file, sync counter with the
// horizontal window, and vertical sync delay. Single clock, synchronous
// active-low reset; the read port is combinational on cfg_addr.
module lsg_line_sync #(
    parameter int CNT_W      = lsg_pkg::CNT_W,
    parameter int DLY_W      = lsg_pkg::DLY_W,
    parameter int STEP_SHIFT = lsg_pkg::STEP_SHIFT,
    parameter int DATA_W     = lsg_pkg::DATA_W,
    parameter int ADDR_W     = lsg_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              vs_in,
    output logic [CNT_W-1:0]  sync_cnt,
    output logic              hc_out,
    output logic              vs_out
);
    logic [CNT_W-1:0] line_len;
    logic [CNT_W-1:0] hc_on;
    logic [CNT_W-1:0] hc_off;
    logic [DLY_W-1:0] vs_dly;

    lsg_regs #(.CNT_W(CNT_W), .DLY_W(DLY_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (cfg_wr),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .line_len (line_len),
        .hc_on    (hc_on),
        .hc_off   (hc_off),
        .vs_dly   (vs_dly)
    );

    lsg_counter #(.CNT_W(CNT_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .len_cfg (line_len),
        .hc_on   (hc_on),
        .hc_off  (hc_off),
        .cnt     (sync_cnt),
        .hc      (hc_out)
    );

    lsg_vsdelay #(.DLY_W(DLY_W), .STEP_SHIFT(STEP_SHIFT)) u_vsdelay (
        .clk    (clk),
        .rst_n  (rst_n),
        .vs_in  (vs_in),
        .vs_dly (vs_dly),
        .vs_out (vs_out)
    );
endmodule

// File: tb/lsg_line_sync_test.sv
module lsg_line_sync_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    typedef struct packed {
        logic [10:0] len;
        logic [10:0] on;
        logic [10:0] off;
    } vec_t;

    // Window table: line length, start, stop.
    localparam vec_t VECS [7] = '{
        '{11'd19, 11'd4,  11'd12},
        '{11'd19, 11'd12, 11'd4 },
        '{11'd15, 11'd7,  11'd7 },
        '{11'd9,  11'd0,  11'd10},
        '{11'd31, 11'd0,  11'd0 },
        '{11'd24, 11'd20, 11'd3 },
        '{11'd7,  11'd1,  11'd0 }
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        vs_in = 1'b0;
    logic [10:0] sync_cnt;
    logic        hc_out;
    logic        vs_out;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    lsg_line_sync uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .vs_in     (vs_in),
        .sync_cnt  (sync_cnt),
        .hc_out    (hc_out),
        .vs_out    (vs_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    // Wait until a fresh wrap has happened (counter just returned to 0).
    task automatic sync_line();
        @(negedge clk);
        while (sync_cnt == 0) @(negedge clk);
        while (sync_cnt != 0) @(negedge clk);
    endtask

    // Measure the rise and fall positions of vs_out for one input pulse.
    task automatic vs_pulse(input int d, input int w, input string rq);
        int rise_k = 0;
        int fall_k = 0;
        wr(8'h30, 16'(d));
        repeat (4) @(negedge clk);
        vs_in = 1'b1;
        for (int k = 1; k < 5000 && fall_k == 0; k++) begin
            @(negedge clk);
            if (vs_out && rise_k == 0) rise_k = k;
            if (!vs_out && rise_k != 0 && fall_k == 0) fall_k = k;
            if (k == w) vs_in = 1'b0;
        end
        chk(rise_k == 8*d + 1, {"R6 rise delay ", rq}, rise_k, 8*d + 1);
        chk(fall_k == w + 8*d + 1, {"R7 fall delay ", rq}, fall_k, w + 8*d + 1);
        chk(fall_k - rise_k == w, {"R7 pulse width ", rq}, fall_k - rise_k, w);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R1..R9 run actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        int last;
        int len_cyc;

        // Reset state (R9).
        repeat (3) @(negedge clk);
        chk(sync_cnt == 0, "R9 counter in reset", sync_cnt, 0);
        chk(vs_out == 1'b0, "R9 vs_out in reset", vs_out, 0);
        rst_n = 1'b1;
        rd(8'h21, d); chk(d == 16'd1295, "R2 line length reset", d, 1295);
        rd(8'h26, d); chk(d == 16'd50,   "R4 start reset", d, 50);
        rd(8'h27, d); chk(d == 16'd800,  "R4 stop reset", d, 800);
        rd(8'h30, d); chk(d == 16'd0,    "R6 delay reset", d, 0);

        // Default line period 1296 (R1).
        sync_line();
        len_cyc = 0;
        do begin @(negedge clk); len_cyc++; end while (sync_cnt != 0);
        chk(len_cyc == 1296, "R1 default period", len_cyc, 1296);

        // Table walk: one full line per vector (R1, R4, R5).
        foreach (VECS[v]) begin
            wr(8'h26, 16'(VECS[v].on));
            wr(8'h27, 16'(VECS[v].off));
            wr(8'h21, 16'(VECS[v].len));
            sync_line();
            for (int i = 0; i <= int'(VECS[v].len); i++) begin
                bit exp_hc;
                if (VECS[v].on <= VECS[v].off)
                    exp_hc = (i >= int'(VECS[v].on)) && (i < int'(VECS[v].off));
                else
                    exp_hc = (i >= int'(VECS[v].on)) || (i < int'(VECS[v].off));
                chk(sync_cnt == 11'(i), "R1 counter value", sync_cnt, i);
                chk(hc_out == exp_hc, (VECS[v].on > VECS[v].off || VECS[v].on == VECS[v].off)
                    ? "R5 window level" : "R4 window level", hc_out, exp_hc);
                @(negedge clk);
            end
            chk(sync_cnt == 0, "R1 wrap after L", sync_cnt, 0);
        end

        // Length change mid-line waits for the wrap (R3).
        wr(8'h21, 16'd19);
        sync_line();
        while (sync_cnt != 5) @(negedge clk);
        wr(8'h21, 16'd9);
        last = 0;
        while (sync_cnt != 0) begin last = sync_cnt; @(negedge clk); end
        chk(last == 19, "R3 current line keeps old end", last, 19);
        @(negedge clk);
        while (sync_cnt != 0) begin last = sync_cnt; @(negedge clk); end
        chk(last == 9, "R3 next line uses new end", last, 9);

        // Reserved bits and unknown subaddresses (R2, R8).
        wr(8'h26, 16'hFFFF);
        rd(8'h26, d); chk(d == 16'h07FF, "R2 reserved bits read zero", d, 16'h07FF);
        wr(8'h26, 16'd3);
        wr(8'h22, 16'hFFFF);
        wr(8'h00, 16'hFFFF);
        wr(8'h31, 16'hFFFF);
        rd(8'h22, d); chk(d == 0, "R8 unknown read zero", d, 0);
        rd(8'hFF, d); chk(d == 0, "R8 unknown read zero", d, 0);
        rd(8'h21, d); chk(d == 16'd9, "R8 length untouched", d, 9);
        rd(8'h26, d); chk(d == 16'd3, "R8 start untouched", d, 3);
        rd(8'h27, d); chk(d == 16'd0, "R8 stop untouched", d, 0);
        rd(8'h30, d); chk(d == 16'd0, "R8 delay untouched", d, 0);

        // Vertical sync delay (R6, R7).
        vs_pulse(0, 5, "D=0");
        vs_pulse(1, 40, "D=1");
        vs_pulse(3, 12, "D=3");
        vs_pulse(2, 3, "D=2 short");
        vs_pulse(255, 20, "D=255");

        // Reset mid-run restores defaults (R9).
        wr(8'h27, 16'd7);
        wr(8'h30, 16'd4);
        @(negedge clk);
        vs_in = 1'b1;
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        vs_in = 1'b0;
        chk(sync_cnt == 0, "R9 counter cleared", sync_cnt, 0);
        chk(vs_out == 1'b0, "R9 vs_out cleared", vs_out, 0);
        rd(8'h21, d); chk(d == 16'd1295, "R9 length default", d, 1295);
        rd(8'h26, d); chk(d == 16'd50,   "R9 start default", d, 50);
        rd(8'h27, d); chk(d == 16'd800,  "R9 stop default", d, 800);
        rd(8'h30, d); chk(d == 16'd0,    "R9 delay default", d, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(hc_out == 1'b0, "R4 window low at counter start", hc_out, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule